// File: doc/BRIEF.md
# Host FIFO Register Port

This block puts a small 32-bit register window in front of four word FIFOs. Two carry packet data: TX data, written by the host and drained by the MAC, and RX data, filled by the MAC and drained by the host. Two carry per-packet status: RX status and TX status. The MAC fills both status FIFOs and the host drains them. The block decodes host reads and writes by byte address. Each data FIFO answers across a run of eight word-spaced aliases, so a host can burst through incrementing addresses and still reach the same FIFO on every beat. Each status FIFO offers two read locations: one removes the oldest word and one only inspects it.

Host accesses are single-cycle strobes. Read data is registered: the word appears on the read-data output in the cycle after the strobe, and that output is zero in any cycle that follows no read. On the MAC side, each FIFO has a valid/ready port and an occupancy count. Host errors never stall the bus. A pop from an empty FIFO and a push into a full one are each recorded in a sticky flag that only reset clears.

Top module: `hfp_host_port`

## Requirements
- R1: After reset all four occupancy counts are zero, both error flags are low, host read data is zero and the MAC TX data valid is low.
- R2: A host write to any word-aligned address from 00h to 1Ch pushes the write data into the TX data FIFO. Words leave on the MAC TX data port in write order, whichever alias each one used.
- R3: A host read of any word-aligned address from 20h to 3Ch pops the oldest RX data word. That word appears on host read data the cycle after the read strobe, and read data is zero after a cycle with no read.
- R4: A host read at 40h pops and returns the oldest RX status word. A read at 44h returns the same word and leaves the FIFO unchanged.
- R5: A host read at 48h pops and returns the oldest TX status word. A read at 4Ch returns it without removing it.
- R6: A host pop of an empty RX data, RX status or TX status FIFO returns zero and leaves the count unchanged. It sets the underrun flag, which stays high until reset.
- R7: A host write into a full TX data FIFO is discarded. It sets the overrun flag, which stays high until reset.
- R8: A peek at 44h or 4Ch on an empty status FIFO returns zero and leaves the underrun flag unchanged.
- R9: The following return zero on read and change no count or flag:
  - unaligned addresses;
  - reads inside the TX data window;
  - writes outside the TX data window;
  - any other address.
- R10: Each MAC push port is ready exactly when its FIFO is below its depth, and the TX data valid is high exactly when that FIFO holds a word. Each count output gives the current number of stored words.
- R11: A host pop and a MAC push on the same FIFO in the same cycle both take effect. The host receives the old head and the new word is stored; if the FIFO was empty the pop underruns and the push still lands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_rd_i | input | 1 | Host read strobe |
| host_wr_i | input | 1 | Host write strobe |
| host_addr_i | input | ADDR_W | Host byte address |
| host_wdata_i | input | DATA_W | Host write data |
| host_rdata_o | output | DATA_W | Registered host read data |
| host_overrun_o | output | 1 | Sticky flag: host pushed into a full FIFO |
| host_underrun_o | output | 1 | Sticky flag: host popped an empty FIFO |
| mac_txd_valid_o | output | 1 | TX data word available |
| mac_txd_ready_i | input | 1 | MAC takes the TX data word |
| mac_txd_data_o | output | DATA_W | Oldest TX data word |
| txd_count_o | output | $clog2(TXD_DEPTH+1) | TX data occupancy |
| mac_rxd_valid_i | input | 1 | MAC offers an RX data word |
| mac_rxd_ready_o | output | 1 | RX data FIFO can accept |
| mac_rxd_data_i | input | DATA_W | RX data word |
| rxd_count_o | output | $clog2(RXD_DEPTH+1) | RX data occupancy |
| mac_rxs_valid_i | input | 1 | MAC offers an RX status word |
| mac_rxs_ready_o | output | 1 | RX status FIFO can accept |
| mac_rxs_data_i | input | DATA_W | RX status word |
| rxs_count_o | output | $clog2(STS_DEPTH+1) | RX status occupancy |
| mac_txs_valid_i | input | 1 | MAC offers a TX status word |
| mac_txs_ready_o | output | 1 | TX status FIFO can accept |
| mac_txs_data_i | input | DATA_W | TX status word |
| txs_count_o | output | $clog2(STS_DEPTH+1) | TX status occupancy |

## Verification
A corrupted read or write pointer shows up one cycle after the next host read. Host read data then carries a word that is out of order or stale, and the reference queues flag it on that read. A wrong occupancy count is visible in the same cycle on the count and ready/valid outputs. A mis-decoded alias or peek address changes a count, or returns data where zero is expected, one cycle after the strobe. A flag that is not sticky drops in the very next cycle.

// File: rtl/hfp_pkg.sv
package hfp_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_RXD,
    SEL_RXS_POP,
    SEL_RXS_PEEK,
    SEL_TXS_POP,
    SEL_TXS_PEEK
  } rsel_e;

  localparam int unsigned TXD_BASE     = 'h00;
  localparam int unsigned RXD_BASE     = 'h20;
  localparam int unsigned WIN_BYTES    = 'h20;  // eight word aliases
  localparam int unsigned RXS_POP_ADR  = 'h40;
  localparam int unsigned RXS_PEEK_ADR = 'h44;
  localparam int unsigned TXS_POP_ADR  = 'h48;
  localparam int unsigned TXS_PEEK_ADR = 'h4C;

  localparam int STS_RX = 0;
  localparam int STS_TX = 1;
endpackage

// File: rtl/hfp_fifo.sv
module hfp_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [W-1:0]  wdata_i,
  input  logic          pop_i,
  output logic [W-1:0]  head_o,
  output logic          full_o,
  output logic          empty_o,
  output logic [CW-1:0] count_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign full_o  = (cnt == CW'(DEPTH));
  assign empty_o = (cnt == '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;
  assign head_o  = mem[rd_ptr];
  assign count_o = cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == PW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == PW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem[wr_ptr] <= wdata_i;
  end
endmodule

// File: rtl/hfp_decode.sv
module hfp_decode
  import hfp_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              txd_push_o,
  output rsel_e             rsel_o
);
  logic aligned, in_txd, in_rxd;

  always_comb begin
    aligned = (addr_i[1:0] == 2'b00);
    in_txd  = aligned && (addr_i >= ADDR_W'(TXD_BASE)) &&
              (addr_i < ADDR_W'(TXD_BASE + WIN_BYTES));
    in_rxd  = aligned && (addr_i >= ADDR_W'(RXD_BASE)) &&
              (addr_i < ADDR_W'(RXD_BASE + WIN_BYTES));
    txd_push_o = wr_i && in_txd;
    rsel_o = SEL_NONE;
    if (rd_i) begin
      if (in_rxd)                                rsel_o = SEL_RXD;
      else if (addr_i == ADDR_W'(RXS_POP_ADR))   rsel_o = SEL_RXS_POP;
      else if (addr_i == ADDR_W'(RXS_PEEK_ADR))  rsel_o = SEL_RXS_PEEK;
      else if (addr_i == ADDR_W'(TXS_POP_ADR))   rsel_o = SEL_TXS_POP;
      else if (addr_i == ADDR_W'(TXS_PEEK_ADR))  rsel_o = SEL_TXS_PEEK;
    end
  end
endmodule

// File: rtl/hfp_host_port.sv
module hfp_host_port
  import hfp_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int TXD_DEPTH = 16,
  parameter int RXD_DEPTH = 16,
  parameter int STS_DEPTH = 8,
  localparam int TXD_CW   = $clog2(TXD_DEPTH + 1),
  localparam int RXD_CW   = $clog2(RXD_DEPTH + 1),
  localparam int STS_CW   = $clog2(STS_DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_rd_i,
  input  logic              host_wr_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_overrun_o,
  output logic              host_underrun_o,
  output logic              mac_txd_valid_o,
  input  logic              mac_txd_ready_i,
  output logic [DATA_W-1:0] mac_txd_data_o,
  output logic [TXD_CW-1:0] txd_count_o,
  input  logic              mac_rxd_valid_i,
  output logic              mac_rxd_ready_o,
  input  logic [DATA_W-1:0] mac_rxd_data_i,
  output logic [RXD_CW-1:0] rxd_count_o,
  input  logic              mac_rxs_valid_i,
  output logic              mac_rxs_ready_o,
  input  logic [DATA_W-1:0] mac_rxs_data_i,
  output logic [STS_CW-1:0] rxs_count_o,
  input  logic              mac_txs_valid_i,
  output logic              mac_txs_ready_o,
  input  logic [DATA_W-1:0] mac_txs_data_i,
  output logic [STS_CW-1:0] txs_count_o
);
  rsel_e             rsel;
  logic              txd_push;
  logic              txd_full, txd_empty, rxd_full, rxd_empty;
  logic [DATA_W-1:0] rxd_head;
  logic [1:0]        sts_push, sts_pop, sts_full, sts_empty;
  logic [DATA_W-1:0] sts_wdata [2];
  logic [DATA_W-1:0] sts_head  [2];
  logic [STS_CW-1:0] sts_count [2];
  logic              rxd_pop;
  logic              underrun_hit;
  logic [DATA_W-1:0] rd_val;

  hfp_decode #(.ADDR_W(ADDR_W)) u_decode (
    .rd_i       (host_rd_i),
    .wr_i       (host_wr_i),
    .addr_i     (host_addr_i),
    .txd_push_o (txd_push),
    .rsel_o     (rsel)
  );

  hfp_fifo #(.W(DATA_W), .DEPTH(TXD_DEPTH)) u_txd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (txd_push),
    .wdata_i (host_wdata_i),
    .pop_i   (mac_txd_ready_i),
    .head_o  (mac_txd_data_o),
    .full_o  (txd_full),
    .empty_o (txd_empty),
    .count_o (txd_count_o)
  );

  assign rxd_pop = (rsel == SEL_RXD);

  hfp_fifo #(.W(DATA_W), .DEPTH(RXD_DEPTH)) u_rxd (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (mac_rxd_valid_i),
    .wdata_i (mac_rxd_data_i),
    .pop_i   (rxd_pop),
    .head_o  (rxd_head),
    .full_o  (rxd_full),
    .empty_o (rxd_empty),
    .count_o (rxd_count_o)
  );

  // status FIFOs: MAC pushes, host pops or peeks
  assign sts_push[STS_RX]  = mac_rxs_valid_i;
  assign sts_push[STS_TX]  = mac_txs_valid_i;
  assign sts_wdata[STS_RX] = mac_rxs_data_i;
  assign sts_wdata[STS_TX] = mac_txs_data_i;
  assign sts_pop[STS_RX]   = (rsel == SEL_RXS_POP);
  assign sts_pop[STS_TX]   = (rsel == SEL_TXS_POP);

  for (genvar g = 0; g < 2; g++) begin : g_sts
    hfp_fifo #(.W(DATA_W), .DEPTH(STS_DEPTH)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .push_i  (sts_push[g]),
      .wdata_i (sts_wdata[g]),
      .pop_i   (sts_pop[g]),
      .head_o  (sts_head[g]),
      .full_o  (sts_full[g]),
      .empty_o (sts_empty[g]),
      .count_o (sts_count[g])
    );
  end

  assign mac_txd_valid_o = !txd_empty;
  assign mac_rxd_ready_o = !rxd_full;
  assign mac_rxs_ready_o = !sts_full[STS_RX];
  assign mac_txs_ready_o = !sts_full[STS_TX];
  assign rxs_count_o     = sts_count[STS_RX];
  assign txs_count_o     = sts_count[STS_TX];

  always_comb begin
    case (rsel)
      SEL_RXD:                   rd_val = rxd_empty ? '0 : rxd_head;
      SEL_RXS_POP, SEL_RXS_PEEK: rd_val = sts_empty[STS_RX] ? '0 : sts_head[STS_RX];
      SEL_TXS_POP, SEL_TXS_PEEK: rd_val = sts_empty[STS_TX] ? '0 : sts_head[STS_TX];
      default:                   rd_val = '0;
    endcase
  end

  assign underrun_hit = (rxd_pop && rxd_empty) ||
                        (sts_pop[STS_RX] && sts_empty[STS_RX]) ||
                        (sts_pop[STS_TX] && sts_empty[STS_TX]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      host_rdata_o    <= '0;
      host_overrun_o  <= 1'b0;
      host_underrun_o <= 1'b0;
    end else begin
      host_rdata_o <= rd_val;
      if (txd_push && txd_full) host_overrun_o <= 1'b1;
      if (underrun_hit)         host_underrun_o <= 1'b1;
    end
  end
endmodule

// File: rtl/hfp_host_port_chk.sv
module hfp_host_port_chk #(
  parameter int ADDR_W    = 8,
  parameter int TXD_DEPTH = 16,
  parameter int RXD_DEPTH = 16,
  parameter int TXD_CW    = 5,
  parameter int RXD_CW    = 5,
  parameter int STS_CW    = 4,
  parameter int DATA_W    = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              host_rd_i,
  input logic              host_wr_i,
  input logic [ADDR_W-1:0] host_addr_i,
  input logic [DATA_W-1:0] host_rdata_o,
  input logic              host_overrun_o,
  input logic              host_underrun_o,
  input logic              mac_txd_valid_o,
  input logic              mac_txd_ready_i,
  input logic [TXD_CW-1:0] txd_count_o,
  input logic              mac_rxd_ready_o,
  input logic [RXD_CW-1:0] rxd_count_o,
  input logic              mac_rxs_valid_i,
  input logic              mac_rxs_ready_o,
  input logic [STS_CW-1:0] rxs_count_o
);
  logic al, a_txd, a_rxd, a_known;
  always_comb begin
    al      = (host_addr_i[1:0] == 2'b00);
    a_txd   = al && (int'(host_addr_i) < 'h20);
    a_rxd   = al && (int'(host_addr_i) >= 'h20) && (int'(host_addr_i) < 'h40);
    a_known = a_rxd || (int'(host_addr_i) == 'h40) || (int'(host_addr_i) == 'h44) ||
              (int'(host_addr_i) == 'h48) || (int'(host_addr_i) == 'h4C);
  end

  // R6
  underrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_underrun_o |=> host_underrun_o);
  // R7
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_overrun_o |=> host_overrun_o);
  // R6
  empty_pop_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && a_rxd && rxd_count_o == '0) |=> (host_rdata_o == '0 && host_underrun_o));
  // R9
  undecoded_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && !a_known) |=> host_rdata_o == '0);
  // R4
  rxs_peek_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_rd_i && int'(host_addr_i) == 'h44 && !(mac_rxs_valid_i && mac_rxs_ready_o))
    |=> rxs_count_o == $past(rxs_count_o));
  // R2
  txd_push_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_wr_i && a_txd && txd_count_o < TXD_CW'(TXD_DEPTH) && !(mac_txd_valid_o && mac_txd_ready_i))
    |=> txd_count_o == TXD_CW'($past(txd_count_o) + 1'b1));
  // R10
  txd_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_txd_valid_o == (txd_count_o != '0));
  // R10
  rxd_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mac_rxd_ready_o == (rxd_count_o < RXD_CW'(RXD_DEPTH)));
endmodule

bind hfp_host_port hfp_host_port_chk #(
  .ADDR_W(ADDR_W), .TXD_DEPTH(TXD_DEPTH), .RXD_DEPTH(RXD_DEPTH),
  .TXD_CW(TXD_CW), .RXD_CW(RXD_CW), .STS_CW(STS_CW), .DATA_W(DATA_W)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .host_rd_i(host_rd_i), .host_wr_i(host_wr_i),
  .host_addr_i(host_addr_i), .host_rdata_o(host_rdata_o),
  .host_overrun_o(host_overrun_o), .host_underrun_o(host_underrun_o),
  .mac_txd_valid_o(mac_txd_valid_o), .mac_txd_ready_i(mac_txd_ready_i),
  .txd_count_o(txd_count_o), .mac_rxd_ready_o(mac_rxd_ready_o),
  .rxd_count_o(rxd_count_o), .mac_rxs_valid_i(mac_rxs_valid_i),
  .mac_rxs_ready_o(mac_rxs_ready_o), .rxs_count_o(rxs_count_o)
);

// File: tb/tb_hfp_host_port.sv
module tb_hfp_host_port;
  localparam int CLK_PERIOD = 10;
  localparam int TXD_DEPTH  = 16;
  localparam int RXD_DEPTH  = 16;
  localparam int STS_DEPTH  = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        h_rd = 0, h_wr = 0;
  logic [7:0]  h_addr = 0;
  logic [31:0] h_wdata = 0;
  logic        txd_rdy = 0, rxd_v = 0, rxs_v = 0, txs_v = 0;
  logic [31:0] rxd_d = 0, rxs_d = 0, txs_d = 0;

  logic [31:0] host_rdata_o, mac_txd_data_o;
  logic        host_overrun_o, host_underrun_o, mac_txd_valid_o;
  logic        mac_rxd_ready_o, mac_rxs_ready_o, mac_txs_ready_o;
  logic [4:0]  txd_count_o, rxd_count_o;
  logic [3:0]  rxs_count_o, txs_count_o;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  logic [31:0] q_txd[$], q_rxd[$], q_rxs[$], q_txs[$];
  logic [31:0] exp_rd = 0;
  bit m_over = 0, m_under = 0;
  string rd_tag = "R3";

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  hfp_host_port #(.TXD_DEPTH(TXD_DEPTH), .RXD_DEPTH(RXD_DEPTH), .STS_DEPTH(STS_DEPTH)) dut (
    .clk_i, .rst_ni,
    .host_rd_i(h_rd), .host_wr_i(h_wr), .host_addr_i(h_addr), .host_wdata_i(h_wdata),
    .host_rdata_o, .host_overrun_o, .host_underrun_o,
    .mac_txd_valid_o, .mac_txd_ready_i(txd_rdy), .mac_txd_data_o, .txd_count_o,
    .mac_rxd_valid_i(rxd_v), .mac_rxd_ready_o, .mac_rxd_data_i(rxd_d), .rxd_count_o,
    .mac_rxs_valid_i(rxs_v), .mac_rxs_ready_o, .mac_rxs_data_i(rxs_d), .rxs_count_o,
    .mac_txs_valid_i(txs_v), .mac_txs_ready_o, .mac_txs_data_i(txs_d), .txs_count_o
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // 0 none, 1 txd window, 2 rxd window, 3 rxs pop, 4 rxs peek, 5 txs pop, 6 txs peek
  function automatic int classify(logic [7:0] a);
    if (a[1:0] != 2'b00) return 0;
    if (a < 8'h20) return 1;
    if (a < 8'h40) return 2;
    case (a)
      8'h40: return 3;
      8'h44: return 4;
      8'h48: return 5;
      8'h4C: return 6;
      default: return 0;
    endcase
  endfunction

  task automatic check_state();
    chk(rd_tag, host_rdata_o, exp_rd);
    chk("R10 txd count", 32'(txd_count_o), 32'(q_txd.size()));
    chk("R10 rxd count", 32'(rxd_count_o), 32'(q_rxd.size()));
    chk("R10 rxs count", 32'(rxs_count_o), 32'(q_rxs.size()));
    chk("R10 txs count", 32'(txs_count_o), 32'(q_txs.size()));
    chk("R10 rxd ready", 32'(mac_rxd_ready_o), 32'(q_rxd.size() < RXD_DEPTH));
    chk("R10 rxs ready", 32'(mac_rxs_ready_o), 32'(q_rxs.size() < STS_DEPTH));
    chk("R10 txs ready", 32'(mac_txs_ready_o), 32'(q_txs.size() < STS_DEPTH));
    chk("R10 txd valid", 32'(mac_txd_valid_o), 32'(q_txd.size() != 0));
    if (q_txd.size() != 0) chk("R2 txd order", mac_txd_data_o, q_txd[0]);
    chk("R7 overrun", 32'(host_overrun_o), 32'(m_over));
    chk("R6 underrun", 32'(host_underrun_o), 32'(m_under));
  endtask

  // apply current inputs for one clock edge, update the model, check at negedge
  task automatic cycle();
    int c = classify(h_addr);
    bit txd_full_pre = q_txd.size() >= TXD_DEPTH;
    bit rxd_full_pre = q_rxd.size() >= RXD_DEPTH;
    bit rxs_full_pre = q_rxs.size() >= STS_DEPTH;
    bit txs_full_pre = q_txs.size() >= STS_DEPTH;
    exp_rd = '0;
    rd_tag = "R9 read";
    if (h_rd) begin
      case (c)
        2: begin rd_tag = "R3 rxd read";
             if (q_rxd.size() != 0) exp_rd = q_rxd.pop_front(); else m_under = 1; end
        3: begin rd_tag = "R4 rxs pop";
             if (q_rxs.size() != 0) exp_rd = q_rxs.pop_front(); else m_under = 1; end
        4: begin rd_tag = "R4 rxs peek"; if (q_rxs.size() != 0) exp_rd = q_rxs[0]; end
        5: begin rd_tag = "R5 txs pop";
             if (q_txs.size() != 0) exp_rd = q_txs.pop_front(); else m_under = 1; end
        6: begin rd_tag = "R5 txs peek"; if (q_txs.size() != 0) exp_rd = q_txs[0]; end
        default: ;
      endcase
    end
    if (txd_rdy && q_txd.size() != 0) void'(q_txd.pop_front());
    if (h_wr && c == 1) begin
      if (!txd_full_pre) q_txd.push_back(h_wdata); else m_over = 1;
    end
    if (rxd_v && !rxd_full_pre) q_rxd.push_back(rxd_d);
    if (rxs_v && !rxs_full_pre) q_rxs.push_back(rxs_d);
    if (txs_v && !txs_full_pre) q_txs.push_back(txs_d);
    @(posedge clk_i);
    @(negedge clk_i);
    check_state();
  endtask

  task automatic idle();
    h_rd = 0; h_wr = 0; txd_rdy = 0; rxd_v = 0; rxs_v = 0; txs_v = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 rdata", host_rdata_o, 0);
    chk("R1 counts", 32'({txd_count_o, rxd_count_o, rxs_count_o, txs_count_o}), 0);
    chk("R1 flags", 32'({host_overrun_o, host_underrun_o}), 0);
    chk("R1 txd valid", 32'(mac_txd_valid_o), 0);
    rst_ni = 1;
    @(negedge clk_i);

    // R8 peeks of empty status FIFOs
    idle(); h_rd = 1; h_addr = 8'h44; cycle();
    h_addr = 8'h4C; cycle();
    chk("R8 no underrun", 32'(host_underrun_o), 0);

    // R9 undecoded: reads of TX window, unaligned, out of range; writes elsewhere
    foreach (q_rxs[i]) ;
    h_rd = 1; h_wr = 1; h_wdata = 32'hDEAD_BEEF; h_addr = 8'h21; cycle();
    h_addr = 8'h08; h_wr = 0; cycle();
    h_addr = 8'h50; h_wr = 1; cycle();
    h_addr = 8'hC4; cycle();
    chk("R9 no effect", 32'({txd_count_o, host_underrun_o, host_overrun_o}), 0);

    // R2 burst writes through all eight TX aliases
    idle();
    for (int i = 0; i < 8; i++) begin
      h_wr = 1; h_addr = 8'(i * 4); h_wdata = 32'h1000_0000 + i; cycle();
    end
    idle(); txd_rdy = 1;
    for (int i = 0; i < 8; i++) cycle();
    idle();

    // R3 MAC fills RX data, host bursts through RX aliases
    for (int i = 0; i < 8; i++) begin rxd_v = 1; rxd_d = 32'h2000_0000 + i; cycle(); end
    idle();
    for (int i = 0; i < 8; i++) begin h_rd = 1; h_addr = 8'(8'h20 + i * 4); cycle(); end
    idle(); cycle();  // R3 rdata returns to zero

    // R4/R5 peek then pop
    rxs_v = 1; rxs_d = 32'hA1; txs_v = 1; txs_d = 32'hB1; cycle();
    rxs_d = 32'hA2; txs_d = 32'hB2; cycle();
    idle();
    h_rd = 1; h_addr = 8'h44; cycle(); cycle();
    h_addr = 8'h40; cycle();
    h_addr = 8'h4C; cycle();
    h_addr = 8'h48; cycle(); cycle();
    h_addr = 8'h40; cycle();

    // R11 simultaneous host pop and MAC push
    idle(); rxd_v = 1; rxd_d = 32'h3333; cycle();
    h_rd = 1; h_addr = 8'h2C; rxd_d = 32'h4444; cycle();
    chk("R11 count kept", 32'(rxd_count_o), 1);
    rxd_v = 0; cycle();

    // R6 empty pop, with a push landing in the same cycle
    idle(); h_rd = 1; h_addr = 8'h20; rxd_v = 1; rxd_d = 32'h5555; cycle();
    chk("R6 underrun set", 32'(host_underrun_o), 1);
    idle(); h_rd = 1; h_addr = 8'h20; cycle();

    // R7 fill TX data then overflow
    idle();
    for (int i = 0; i <= TXD_DEPTH; i++) begin
      h_wr = 1; h_addr = 8'h1C; h_wdata = 32'h6000_0000 + i; cycle();
    end
    chk("R7 full count", 32'(txd_count_o), TXD_DEPTH);
    idle(); txd_rdy = 1;
    for (int i = 0; i < TXD_DEPTH; i++) cycle();

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 9);
      h_rd = ($urandom % 2) != 0;
      h_wr = ($urandom % 3) == 0;
      case (r)
        0, 1: h_addr = 8'(($urandom % 8) * 4);
        2, 3: h_addr = 8'(8'h20 + ($urandom % 8) * 4);
        4: h_addr = 8'h40;
        5: h_addr = 8'h44;
        6: h_addr = 8'h48;
        7: h_addr = 8'h4C;
        default: h_addr = 8'($urandom);
      endcase
      h_wdata = $urandom;
      txd_rdy = ($urandom % 4) == 0;
      rxd_v = ($urandom % 2) != 0; rxd_d = $urandom;
      rxs_v = ($urandom % 3) == 0; rxs_d = $urandom;
      txs_v = ($urandom % 3) == 0; txs_d = $urandom;
      cycle();
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule